// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block carries 18-bit words from one clock domain to another through a 512-entry array. The producer side runs on its own write clock. It presents a word with a write strobe and watches an input-ready flag. The consumer side runs on a separate read clock, which may be unrelated to the write clock or may be the very same net. That side has a registered output word, an output-ready flag and a read strobe.

The output is first-word-fall-through. When a word reaches an empty FIFO, it moves into the output register by itself. Output-ready rises on that same read edge, so a high output-ready always means a valid word is already present on the data output. A read strobe consumes the word shown. The next stored word, if there is one, replaces it on the same edge.

The write and read positions cross between the domains as Gray-coded counters through two-stage synchronisers. A half-full flag is kept on the write side. A single synchronous reset is sampled by both clocks and clears both domains.

Top module: `xfifo_fwft`

## Requirements
- R1: Words leave in exactly the order they were accepted. With no reads, the block accepts 513 words before input-ready falls: 512 held in the array plus the one that has fallen into the output register.
- R2: Input-ready is low whenever the array is full. A write strobed while input-ready is low is discarded: it is never stored or delivered later. Input-ready rises again after the consumer frees space.
- R3: Output-ready is low whenever no word is available. A read strobed while output-ready is low is discarded: it consumes no word, so the next word written still appears afterwards.
- R4: With both clocks on one net, a word written into an empty FIFO on write edge E is driven on the data output on read edge E+3. Output-ready rises on that same edge E+3 and is still low after edges E+1 and E+2.
- R5: Once the last word is read and output-ready falls, the data output keeps showing that last word until a new word falls through.
- R6: Half-full is high when the array holds 256 or more words and low when it holds 255 or fewer. The word sitting in the output register is not counted.
- R7: While reset is high, input-ready, output-ready and half-full are all low. After reset is released, input-ready is still low after the first write-clock edge and is high after the second.
- R8: Writes and reads may happen on the same edge, on one shared clock or on two unrelated clocks. The stream then stays loss-free and in order. This includes the case where the output register is consumed and refilled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, free-running |
| rclk | input | 1 | Read-side clock, free-running, may equal wclk |
| rst | input | 1 | Synchronous active-high reset, held for several edges of both clocks |
| wr_en | input | 1 | Write strobe; stores wr_data when in_ready is high |
| wr_data | input | 18 | Word to store |
| in_ready | output | 1 | High when the FIFO can accept a word |
| half_full | output | 1 | High when the array holds at least half its depth |
| rd_en | input | 1 | Read strobe; consumes the shown word when out_ready is high |
| rd_data | output | 18 | Output register holding the oldest unread word |
| out_ready | output | 1 | High when rd_data holds an unread word |

## Verification
Two things can land on one read edge. The consumer can take the word in the output register, and the next stored word can fall into that register. A correct design must perform both at once, with no word dropped and none shown twice. The bench provokes this by streaming with strobes held high for runs of cycles, first with both clocks tied to one net and then with unrelated periods. Every delivered word is compared against a counter of the words accepted. The fill test adds a second kind of collision. It aims writes at a full FIFO while the pointer from the other domain is frozen, and then judges from the drained sequence that none of those writes leaked in.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable: this register is the FIFO output stage
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
  import xfifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  output logic        in_ready,
  output logic        half_full,
  output logic        we,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray
);
  localparam int PW   = AW + 1;
  localparam int HALF = 1 << (AW - 1);

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, occ_nxt;
  logic          armed, push, full_nxt;

  assign push     = wr_en & in_ready;
  assign wbin_nxt = wbin + PW'(push);
  assign rbin_s   = PW'(from_gray(32'(rgray_sync)));
  assign occ_nxt  = wbin_nxt - rbin_s;
  assign full_nxt = (wbin_nxt[AW-1:0] == rbin_s[AW-1:0]) && (wbin_nxt[AW] != rbin_s[AW]);
  assign we       = push;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      armed     <= 1'b0;
      in_ready  <= 1'b0;
      half_full <= 1'b0;
    end else begin
      wbin      <= wbin_nxt;
      wgray     <= PW'(to_gray(32'(wbin_nxt)));
      armed     <= 1'b1;
      in_ready  <= armed & ~full_nxt;
      half_full <= (occ_nxt >= PW'(HALF));
    end
  end
endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
  import xfifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic [AW:0] wgray_sync,
  output logic        out_ready,
  output logic        re,
  output logic [AW-1:0] raddr,
  output logic [AW:0] rgray
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_inc;
  logic          have, fetch;

  assign have     = (rgray != wgray_sync);
  assign fetch    = have & (~out_ready | rd_en);
  assign rbin_inc = rbin + PW'(1);
  assign re       = fetch;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rgray     <= '0;
      out_ready <= 1'b0;
    end else if (fetch) begin
      rbin      <= rbin_inc;
      rgray     <= PW'(to_gray(32'(rbin_inc)));
      out_ready <= 1'b1;
    end else if (rd_en) begin
      out_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/xfifo_fwft.sv
module xfifo_fwft #(
  parameter int DW    = 18,
  parameter int DEPTH = 512
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_ready,
  output logic          half_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_r, rgray_w;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;

  xfifo_sync #(.W(PW)) u_rsync (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_w));
  xfifo_sync #(.W(PW)) u_wsync (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_r));

  xfifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wclk), .rst(rst), .wr_en(wr_en), .rgray_sync(rgray_w),
    .in_ready(in_ready), .half_full(half_full),
    .we(we), .waddr(waddr), .wgray(wgray)
  );

  xfifo_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rclk), .rst(rst), .rd_en(rd_en), .wgray_sync(wgray_r),
    .out_ready(out_ready), .re(re), .raddr(raddr), .rgray(rgray)
  );

  xfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/xfifo_fwft_chk.sv
module xfifo_fwft_chk #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_en,
  input logic          in_ready,
  input logic          half_full,
  input logic          out_ready,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [AW:0]   wgray_r
);
  // R2: a strobe against a full FIFO leaves the write position untouched
  assert_wr_ignored_R2: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && !in_ready) |=> $stable(wgray));

  // R3: with nothing visible from the write side, the read position stays put
  assert_no_underflow_R3: assert property (@(posedge rclk) disable iff (rst)
    (rgray == wgray_r) |=> $stable(rgray));

  // R5: the edge that drops output-ready leaves the shown word alone
  assert_hold_last_R5: assert property (@(posedge rclk) disable iff (rst)
    $fell(out_ready) |-> $stable(rd_data));

  // R1: crossing positions move by at most one bit per edge
  assert_wgray_step_R1: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R1: assert property (@(posedge rclk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R7: reset clears the flags in both domains
  assert_reset_wr_R7: assert property (@(posedge wclk)
    rst |=> (!in_ready && !half_full));
  assert_reset_rd_R7: assert property (@(posedge rclk)
    rst |=> !out_ready);
endmodule

bind xfifo_fwft xfifo_fwft_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .in_ready(in_ready),
  .half_full(half_full), .out_ready(out_ready), .rd_data(rd_data),
  .wgray(wgray), .rgray(rgray), .wgray_r(wgray_r)
);

// File: tb/xfifo_fwft_tb.sv
module xfifo_fwft_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_HALF   = 7;
  localparam int DW         = 18;
  localparam int DEPTH      = 512;

  logic wclk = 1'b0, aclk = 1'b0, same_clk = 1'b1;
  logic rclk;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic in_ready, half_full, out_ready;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(ALT_HALF) aclk = ~aclk;
  assign rclk = same_clk ? wclk : aclk;

  xfifo_fwft #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .in_ready(in_ready), .half_full(half_full), .rd_en(rd_en),
    .rd_data(rd_data), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit shared);
    rst = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    same_clk = shared;
    repeat (10) @(posedge wclk);
    @(negedge wclk);
    rst = 1'b0;
  endtask

  task automatic wr_word(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    acc = in_ready;
    wr_en = 1'b1;
    wr_data = d;
    @(posedge wclk);
  endtask

  task automatic wr_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    same_clk = 1'b1;
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    chk(!in_ready && !out_ready && !half_full, "R7", "flags in reset",
        {in_ready, out_ready, half_full}, 0);
    rst = 1'b0;
    @(negedge wclk);
    chk(!in_ready, "R7", "in_ready after edge 1", in_ready, 0);
    @(negedge wclk);
    chk(in_ready, "R7", "in_ready after edge 2", in_ready, 1);
  endtask

  task automatic t_latency_and_empty;
    bit acc;
    do_reset(1'b1);
    repeat (3) @(negedge wclk);
    wr_word(18'h1a5a5, acc);
    @(negedge wclk);
    wr_en = 1'b0;
    chk(!out_ready, "R4", "out_ready after E", out_ready, 0);
    @(negedge wclk);
    chk(!out_ready, "R4", "out_ready after E+1", out_ready, 0);
    @(negedge wclk);
    chk(!out_ready, "R4", "out_ready after E+2", out_ready, 0);
    @(negedge wclk);
    chk(out_ready, "R4", "out_ready after E+3", out_ready, 1);
    chk(rd_data == 18'h1a5a5, "R4", "word falls through", rd_data, 18'h1a5a5);
    rd_en = 1'b1;
    @(negedge wclk);
    chk(!out_ready, "R3", "out_ready after last read", out_ready, 0);
    chk(rd_data == 18'h1a5a5, "R5", "last word held", rd_data, 18'h1a5a5);
    repeat (5) @(negedge wclk);
    chk(rd_data == 18'h1a5a5 && !out_ready, "R5", "held under empty reads",
        rd_data, 18'h1a5a5);
    rd_en = 1'b0;
    wr_word(18'h00c3c, acc);
    @(negedge wclk);
    wr_en = 1'b0;
    repeat (5) @(negedge wclk);
    chk(out_ready, "R3", "new word visible after empty reads", out_ready, 1);
    chk(rd_data == 18'h00c3c, "R3", "no word lost to empty reads", rd_data, 18'h00c3c);
    rd_en = 1'b1;
    @(negedge wclk);
    rd_en = 1'b0;
    repeat (3) @(negedge wclk);
    chk(!out_ready, "R3", "empty again", out_ready, 0);
  endtask

  task automatic t_fill_drain;
    bit acc;
    int n, k, idle;
    do_reset(1'b0);
    repeat (3) @(negedge wclk);
    wr_word(18'(0), acc);
    wr_idle(12);
    for (int i = 1; i < 256; i++) wr_word(18'(i), acc);
    wr_idle(3);
    chk(!half_full, "R6", "255 words in array", half_full, 0);
    wr_word(18'(256), acc);
    wr_idle(3);
    chk(half_full, "R6", "256 words in array", half_full, 1);
    n = 257;
    while (n < 600) begin
      wr_word(18'(n), acc);
      if (!acc) break;
      n++;
    end
    wr_idle(20);
    chk(n == 513, "R1", "accepted before full", n, 513);
    chk(!in_ready, "R2", "in_ready low when full", in_ready, 0);
    for (int i = 0; i < 3; i++) wr_word(18'h3ffff, acc);
    wr_idle(2);
    k = 0;
    idle = 0;
    while (idle < 30) begin
      @(negedge rclk);
      if (out_ready) begin
        if (rd_data != 18'(k))
          chk(1'b0, "R1", "drain order", rd_data, 18'(k));
        k++;
        rd_en = 1'b1;
        idle = 0;
      end else begin
        rd_en = 1'b0;
        idle++;
      end
    end
    rd_en = 1'b0;
    chk(k == 513, "R2", "words drained, full writes ignored", k, 513);
    chk(rd_data == 18'(512), "R5", "last word held after drain", rd_data, 512);
    wr_idle(6);
    chk(!half_full, "R6", "half_full low after drain", half_full, 0);
    chk(in_ready, "R2", "in_ready back after drain", in_ready, 1);
  endtask

  task automatic t_stream(input bit shared, input int n, input int base);
    int got, bad, cyc;
    do_reset(shared);
    repeat (3) @(negedge wclk);
    got = 0;
    bad = 0;
    fork
      begin
        int i;
        i = 0;
        cyc = 0;
        while (i < n) begin
          @(negedge wclk);
          cyc++;
          if (in_ready && (cyc % 9 != 0)) begin
            wr_en = 1'b1;
            wr_data = 18'(base + i);
            i++;
          end else begin
            wr_en = 1'b0;
          end
        end
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        int rc;
        rc = 0;
        while (got < n) begin
          @(negedge rclk);
          rc++;
          if (out_ready && (rc % 11 != 0)) begin
            if (rd_data != 18'(base + got)) bad++;
            got++;
            rd_en = 1'b1;
          end else begin
            rd_en = 1'b0;
          end
        end
        @(negedge rclk);
        rd_en = 1'b0;
      end
    join
    chk(bad == 0, "R8", "stream order with overlapping strobes", bad, 0);
    chk(got == n, "R8", "stream count", got, n);
    repeat (8) @(negedge rclk);
    chk(!out_ready, "R8", "no extra word after stream", out_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency_and_empty();
    t_stream(1'b1, 700, 1000);
    t_fill_drain();
    t_stream(1'b0, 700, 5000);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule